// File: doc/BRIEF.md
# Texture Miss Reorder Unit

This block is the miss-handling front end of a read-only texture cache. Each lookup that it accepts, hit or miss, claims one slot in a circular reorder buffer. The slot records the set index, the block address and the requester's tag. On a miss, the unit marks the tag entry valid in the same cycle, before any data exists. It then queues one memory request covering the whole line.

When the access is made in sector mode, that queued request is issued to memory as a run of sector-sized sub-requests. The slot keeps a count of outstanding sub-responses. Each returning response counts it down, and only the last one marks the slot filled.

Completed slots leave strictly from the head of the buffer. A fast fill therefore never overtakes an older access that is still waiting. Lookups stall whenever either the reorder buffer or the request queue has no room.

Top module: `tex_miss_reorder`

## Requirements
- R1: `acc_ready` is high exactly when the reorder buffer holds fewer than ROB_DEPTH slots and the request queue holds fewer than FIFO_DEPTH entries. An access offered while `acc_ready` is low is not taken.
- R2: In the cycle that a miss is accepted, `tag_wr` is high and `tag_wr_index` equals `acc_index`. An accepted hit, or a cycle with no accepted access, leaves `tag_wr` low.
- R3: An accepted miss queues one request. Requests leave in acceptance order, each carrying its block address and its reorder slot on `req_slot`. A line-mode request is issued once, with `req_sector` 0 and `req_size` equal to LINE_BYTES.
- R4: A miss accepted while `sector_mode` is 1 is issued as SECTORS consecutive handshakes. They carry `req_sector` 0, 1, … SECTORS-1 in that order, each with `req_size` equal to LINE_BYTES/SECTORS.
- R5: A miss slot starts with a pending count equal to the number of sub-requests it issues (1 in line mode, SECTORS in sector mode). Each `rsp_valid` naming that slot on `rsp_slot` decrements the count. The slot becomes ready only in the cycle after the count reaches zero, and earlier responses have no visible effect.
- R6: An accepted hit occupies a slot that is ready at once and issues no memory request.
- R7: Slots are assigned in order 0, 1, … ROB_DEPTH-1 and wrap around, starting from 0 after reset. `ret_valid` is high only while the oldest slot is ready. It then presents that slot's index, block and identifier, and the slot is released at the next clock edge.
- R8: After reset, no slot and no request is held: `acc_ready` is high, and `req_valid`, `ret_valid` and `tag_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sector_mode | input | 1 | Split a miss into sector sub-requests |
| acc_valid | input | 1 | Lookup offered |
| acc_hit | input | 1 | Lookup hit the tag array |
| acc_index | input | IDX_W | Cache set/way index of the lookup |
| acc_block | input | BLK_W | Block address of the lookup |
| acc_id | input | ID_W | Requester tag |
| acc_ready | output | 1 | Lookup can be accepted |
| tag_wr | output | 1 | Mark tag entry valid now |
| tag_wr_index | output | IDX_W | Index of the tag entry to mark |
| req_valid | output | 1 | Memory request available |
| req_ready | input | 1 | Memory accepts the request |
| req_block | output | BLK_W | Block address of the request |
| req_slot | output | RW | Reorder slot that owns the request |
| req_sector | output | SW | Sector number within the line |
| req_size | output | ZW | Bytes requested |
| rsp_valid | input | 1 | A (sub-)response returned |
| rsp_slot | input | RW | Slot the response belongs to |
| ret_valid | output | 1 | Head slot retires this cycle |
| ret_index | output | IDX_W | Index of the retiring slot |
| ret_block | output | BLK_W | Block address of the retiring slot |
| ret_id | output | ID_W | Requester tag of the retiring slot |

## Verification
The assertions assume that a response only ever names a slot that is allocated, not yet ready and still owed data. They also assume at most one response per cycle. The stimulus keeps to this by counting, per slot, the sub-requests that have completed a handshake and the responses already sent. It answers only slots where the first count exceeds the second, choosing among them at random so that fills return out of order. The `sector_mode` input is toggled freely, because each slot and queue entry keeps the mode it was accepted with.

// File: rtl/tex_miss_reorder.sv
module tex_miss_reorder #(
  parameter int IDX_W = 6,
  parameter int BLK_W = 20,
  parameter int ID_W = 4,
  parameter int ROB_DEPTH = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int SECTORS = 4,
  parameter int LINE_BYTES = 128,
  localparam int RW = $clog2(ROB_DEPTH),
  localparam int FW = $clog2(FIFO_DEPTH),
  localparam int SW = $clog2(SECTORS),
  localparam int CW = $clog2(SECTORS + 1),
  localparam int ZW = $clog2(LINE_BYTES + 1),
  localparam int SECT_BYTES = LINE_BYTES / SECTORS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sector_mode,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [IDX_W-1:0] acc_index,
  input  logic [BLK_W-1:0] acc_block,
  input  logic [ID_W-1:0]  acc_id,
  output logic             acc_ready,
  output logic             tag_wr,
  output logic [IDX_W-1:0] tag_wr_index,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [BLK_W-1:0] req_block,
  output logic [RW-1:0]    req_slot,
  output logic [SW-1:0]    req_sector,
  output logic [ZW-1:0]    req_size,
  input  logic             rsp_valid,
  input  logic [RW-1:0]    rsp_slot,
  output logic             ret_valid,
  output logic [IDX_W-1:0] ret_index,
  output logic [BLK_W-1:0] ret_block,
  output logic [ID_W-1:0]  ret_id
);

  // reorder buffer
  logic [RW:0] hd, tl;
  logic [ROB_DEPTH-1:0] r_vld, r_rdy;
  logic [CW-1:0]    r_pend [ROB_DEPTH];
  logic [IDX_W-1:0] r_idx  [ROB_DEPTH];
  logic [BLK_W-1:0] r_blk  [ROB_DEPTH];
  logic [ID_W-1:0]  r_id   [ROB_DEPTH];

  // request queue
  logic [FW:0] fhd, ftl;
  logic [RW-1:0]    f_slot [FIFO_DEPTH];
  logic [BLK_W-1:0] f_blk  [FIFO_DEPTH];
  logic [FIFO_DEPTH-1:0] f_sec;
  logic [SW-1:0] sub;

  logic [RW-1:0] hp, tp;
  logic [FW-1:0] fh, ft;
  logic rob_full, fifo_full, take, miss, req_last, req_fire;

  assign hp = hd[RW-1:0];
  assign tp = tl[RW-1:0];
  assign fh = fhd[FW-1:0];
  assign ft = ftl[FW-1:0];

  assign rob_full  = (hd[RW] != tl[RW]) && (hp == tp);
  assign fifo_full = (fhd[FW] != ftl[FW]) && (fh == ft);
  assign acc_ready = !rob_full && !fifo_full;
  assign take = acc_valid && acc_ready;
  assign miss = take && !acc_hit;

  assign tag_wr = miss;
  assign tag_wr_index = acc_index;

  assign req_valid  = (fhd != ftl);
  assign req_block  = f_blk[fh];
  assign req_slot   = f_slot[fh];
  assign req_sector = f_sec[fh] ? sub : '0;
  assign req_size   = f_sec[fh] ? ZW'(SECT_BYTES) : ZW'(LINE_BYTES);
  assign req_last   = !f_sec[fh] || (sub == SW'(SECTORS - 1));
  assign req_fire   = req_valid && req_ready;

  assign ret_valid = r_vld[hp] && r_rdy[hp];
  assign ret_index = r_idx[hp];
  assign ret_block = r_blk[hp];
  assign ret_id    = r_id[hp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd <= '0;
      tl <= '0;
      r_vld <= '0;
      r_rdy <= '0;
    end else begin
      if (ret_valid) begin
        r_vld[hp] <= 1'b0;
        r_rdy[hp] <= 1'b0;
        hd <= hd + 1'b1;
      end
      if (rsp_valid && r_pend[rsp_slot] == CW'(1))
        r_rdy[rsp_slot] <= 1'b1;
      if (take) begin
        r_vld[tp] <= 1'b1;
        r_rdy[tp] <= acc_hit;
        tl <= tl + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid)
      r_pend[rsp_slot] <= r_pend[rsp_slot] - CW'(1);
    if (take) begin
      r_idx[tp]  <= acc_index;
      r_blk[tp]  <= acc_block;
      r_id[tp]   <= acc_id;
      r_pend[tp] <= acc_hit ? '0 : (sector_mode ? CW'(SECTORS) : CW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fhd <= '0;
      ftl <= '0;
      sub <= '0;
    end else begin
      if (miss)
        ftl <= ftl + 1'b1;
      if (req_fire) begin
        if (req_last) begin
          sub <= '0;
          fhd <= fhd + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (miss) begin
      f_slot[ft] <= tp;
      f_blk[ft]  <= acc_block;
      f_sec[ft]  <= sector_mode;
    end
  end

endmodule

module tex_miss_reorder_chk #(
  parameter int ROB_DEPTH = 4,
  parameter int SECTORS = 4,
  parameter int LINE_BYTES = 128,
  localparam int RW = $clog2(ROB_DEPTH),
  localparam int ZW = $clog2(LINE_BYTES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic                 acc_hit,
  input logic                 acc_ready,
  input logic                 tag_wr,
  input logic                 req_valid,
  input logic [ZW-1:0]        req_size,
  input logic                 rsp_valid,
  input logic [RW-1:0]        rsp_slot,
  input logic                 ret_valid,
  input logic [RW:0]          hd,
  input logic [RW:0]          tl,
  input logic [ROB_DEPTH-1:0] r_vld,
  input logic [ROB_DEPTH-1:0] r_rdy
);
  logic [RW:0] occ;
  assign occ = tl - hd;

  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == (RW+1)'(ROB_DEPTH)) |-> !acc_ready);

  p_hit_no_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |-> !tag_wr);

  p_miss_queued_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !acc_hit) |=> req_valid);

  p_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size == ZW'(LINE_BYTES) || req_size == ZW'(LINE_BYTES / SECTORS)));

  p_rsp_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (r_vld[rsp_slot] && !r_rdy[rsp_slot]));

  p_in_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (hd == $past(hd) + 1'b1));
endmodule

bind tex_miss_reorder tex_miss_reorder_chk #(
  .ROB_DEPTH(ROB_DEPTH), .SECTORS(SECTORS), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
  .acc_ready(acc_ready), .tag_wr(tag_wr), .req_valid(req_valid),
  .req_size(req_size), .rsp_valid(rsp_valid), .rsp_slot(rsp_slot),
  .ret_valid(ret_valid), .hd(hd), .tl(tl), .r_vld(r_vld), .r_rdy(r_rdy)
);

// File: tb/test_tex_miss_reorder.sv
`timescale 1ns/1ps
module test_tex_miss_reorder;
  localparam int RD = 4, FD = 4, NS = 4, LB = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sector_mode = 1'b0, acc_valid = 1'b0, acc_hit = 1'b0;
  logic [5:0] acc_index = '0;
  logic [19:0] acc_block = '0;
  logic [3:0] acc_id = '0;
  logic acc_ready, tag_wr, req_valid, ret_valid;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic [5:0] tag_wr_index, ret_index;
  logic [19:0] req_block, ret_block;
  logic [1:0] req_slot, req_sector, rsp_slot = '0;
  logic [7:0] req_size;
  logic [3:0] ret_id;

  always #2.5 clk = ~clk;

  tex_miss_reorder i_tex_miss_reorder (
    .clk(clk), .rst_n(rst_n), .sector_mode(sector_mode),
    .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_index(acc_index),
    .acc_block(acc_block), .acc_id(acc_id), .acc_ready(acc_ready),
    .tag_wr(tag_wr), .tag_wr_index(tag_wr_index),
    .req_valid(req_valid), .req_ready(req_ready), .req_block(req_block),
    .req_slot(req_slot), .req_sector(req_sector), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_slot(rsp_slot),
    .ret_valid(ret_valid), .ret_index(ret_index), .ret_block(ret_block),
    .ret_id(ret_id)
  );

  int n_chk = 0, n_err = 0;

  // bench model
  int m_pend[RD], m_idx[RD], m_blk[RD], m_id[RD], issued[RD], returned[RD];
  bit m_vld[RD], m_rdy[RD];
  int hd = 0, tl = 0, cnt = 0, sub = 0;
  int q_slot[$], q_blk[$];
  bit q_sec[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_size(input bit sec);
    return sec ? LB / NS : LB;
  endfunction

  function automatic int exp_pend(input bit hit, input bit sec);
    return hit ? 0 : (sec ? NS : 1);
  endfunction

  task automatic step(input int pa, input int pq, input int pr);
    bit av, hit, sm, qr, rv, exp_rdy, exp_ret, qv;
    int idx, blk, id, rs, h, t;
    int cand[$];
    @(negedge clk);
    av = ($urandom_range(99) < pa);
    hit = ($urandom_range(3) == 0);
    sm = $urandom_range(1);
    idx = $urandom_range(63);
    blk = $urandom_range(20'hFFFFF);
    id = $urandom_range(15);
    qr = ($urandom_range(99) < pq);
    for (int i = 0; i < RD; i++)
      if (m_vld[i] && !m_rdy[i] && issued[i] > returned[i]) cand.push_back(i);
    rv = (cand.size() > 0) && ($urandom_range(99) < pr);
    rs = rv ? cand[$urandom_range(cand.size() - 1)] : 0;
    acc_valid = av; acc_hit = hit; sector_mode = sm;
    acc_index = 6'(idx); acc_block = 20'(blk); acc_id = 4'(id);
    req_ready = qr; rsp_valid = rv; rsp_slot = 2'(rs);
    #1;
    exp_rdy = (cnt < RD) && (q_slot.size() < FD);
    chk(acc_ready == exp_rdy, "R1 acc_ready", acc_ready, exp_rdy);
    chk(tag_wr == (av && exp_rdy && !hit), "R2 tag_wr", tag_wr, av && exp_rdy && !hit);
    if (tag_wr) chk(tag_wr_index == 6'(idx), "R2 tag_wr_index", tag_wr_index, idx);
    qv = (q_slot.size() > 0);
    chk(req_valid == qv, "R3 req_valid", req_valid, qv);
    if (qv) begin
      chk(int'(req_block) == q_blk[0], "R3 req_block", req_block, q_blk[0]);
      chk(int'(req_slot) == q_slot[0], "R3 req_slot", req_slot, q_slot[0]);
      chk(int'(req_sector) == (q_sec[0] ? sub : 0), "R4 req_sector", req_sector, q_sec[0] ? sub : 0);
      chk(int'(req_size) == exp_size(q_sec[0]), "R4 req_size", req_size, exp_size(q_sec[0]));
    end
    h = hd % RD;
    exp_ret = m_vld[h] && m_rdy[h];
    chk(ret_valid == exp_ret, "R5 ret_valid", ret_valid, exp_ret);
    if (exp_ret) begin
      chk(int'(ret_index) == m_idx[h], "R7 ret_index", ret_index, m_idx[h]);
      chk(int'(ret_block) == m_blk[h], "R7 ret_block", ret_block, m_blk[h]);
      chk(int'(ret_id) == m_id[h], "R7 ret_id", ret_id, m_id[h]);
    end
    @(posedge clk);
    if (exp_ret) begin
      m_vld[h] = 0; m_rdy[h] = 0; hd++; cnt--;
    end
    if (rv) begin
      m_pend[rs]--; returned[rs]++;
      if (m_pend[rs] == 0) m_rdy[rs] = 1;
    end
    if (qv && qr) begin
      issued[q_slot[0]]++;
      if (!q_sec[0] || sub == NS - 1) begin
        sub = 0;
        void'(q_slot.pop_front()); void'(q_blk.pop_front()); void'(q_sec.pop_front());
      end else sub++;
    end
    if (av && exp_rdy) begin
      t = tl % RD;
      m_vld[t] = 1; m_rdy[t] = hit;  // R6: hit ready at once
      m_pend[t] = exp_pend(hit, sm);
      m_idx[t] = idx; m_blk[t] = blk; m_id[t] = id;
      issued[t] = 0; returned[t] = 0;
      tl++; cnt++;
      if (!hit) begin
        q_slot.push_back(t); q_blk.push_back(blk); q_sec.push_back(sm);
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8 reset state
    chk(acc_ready == 1'b1, "R8 acc_ready", acc_ready, 1);
    chk(req_valid == 1'b0, "R8 req_valid", req_valid, 0);
    chk(ret_valid == 1'b0, "R8 ret_valid", ret_valid, 0);
    chk(tag_wr == 1'b0, "R8 tag_wr", tag_wr, 0);
    // R1: memory stalled, queue fills
    repeat (40) step(90, 0, 0);
    // R5/R7: memory accepts, no responses, ROB fills
    repeat (40) step(90, 100, 0);
    // responses drain out of order
    repeat (60) step(0, 100, 60);
    // mixed random traffic, R3 R4 R6
    repeat (4000) step(60, 70, 50);
    repeat (200) step(0, 100, 80);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule